// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle datapath that a sequencer steers by presenting one 17-bit control word per clock. A small register file has two combinational read ports. One drives bus A. The other drives bus B through a selector that can substitute an external constant. A shared function unit works on the two buses and performs arithmetic, bitwise logic and single-position shifts. A write-back selector then chooses either the function result or an external data word, and that value is stored in the destination register on the rising clock edge.

Bus A and bus B are brought out as an address output and a data output. Four status flags describe the operation of the current cycle: carry, signed overflow, zero and sign. The block has no state machine. All of its sequencing comes from the control words that arrive one per cycle.

Top module: `ctlword_datapath`

## Requirements
- R1: While reset is low, all writable registers are cleared to zero. After reset is released, every register reads back as zero on both buses.
- R2: The control word has these fields, from most significant to least significant. Bits [16:14] name the destination register. Bits [13:11] name the bus A source and bits [10:8] name the bus B source. Bit [7] selects the constant. Bits [6:2] are the function code. Bit [1] selects the write-back source and bit [0] enables the write. The address output always shows the register named by the bus A field.
- R3: When bit [7] is 0, the data output shows the register named by the bus B field. When bit [7] is 1, it shows the constant input instead, and the function unit uses the constant as its B operand.
- R4: When bit [0] is 1, the selected value is written into the destination register at the rising clock edge. When bit [0] is 0, no register changes.
- R5: When bit [1] is 1, the external data input is written back. When bit [1] is 0, the function unit result is written back.
- R6: Register 0 always reads as zero, and writes addressed to it have no effect.
- R7: Each arithmetic code adds A, an operand Y and a carry-in. Code 00000 gives A. Code 00001 gives A+1. Code 00010 gives A+B and code 00011 gives A+B+1. Code 00100 gives A+not(B) and code 00101 gives A+not(B)+1, which is A−B. Code 00110 gives A−1. Code 00111 gives A, with a carry out of 1.
- R8: Code 01000 gives A AND B. Code 01010 gives A OR B. Code 01100 gives A XOR B. Code 01110 gives NOT A.
- R9: Code 10000 passes B. Code 10100 shifts B right by one and code 11000 shifts B left by one. In both shifts the vacated bit is filled with 0 and the bit shifted out is dropped.
- R10: For arithmetic codes (00000 to 00111), C is the unsigned carry out and V flags signed two's-complement overflow. For every other code, C and V are both 0.
- R11: Z is 1 exactly when the result is all zeros, and S equals the most significant bit of the result. Any function code not listed above produces a result of zero.
- R12: The control word 0x05315 stores R2 − R3 into R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_word | input | 17 | Control word for the current cycle |
| const_in | input | 8 | Constant that can replace the bus B register |
| ext_data | input | 8 | External data that can be written back |
| addr_out | output | 8 | Bus A value |
| data_out | output | 8 | Bus B value |
| flag_c | output | 1 | Carry out |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result sign bit |

## Verification
The bench drives the carry and overflow boundaries in several ways.
- Incrementing 0x7F and decrementing 0x80 must raise V. A design whose overflow term is wrong would leave V low here.
- Incrementing 0xFF must wrap to zero with C and Z both set.
- Subtracting a register from itself must set carry and zero. A design that inverted the borrow would show C low.
- Code 00111 must carry out while returning A unchanged.

It shifts 0x81 both ways so that a shift that rotated instead of filling with zero would leave a wrong bit behind. It writes to register 0, writes with the enable low, and feeds unlisted function codes, then reads back through the buses to prove that nothing moved. A design that stored into register 0 would show a nonzero bus A value in the next cycle. Finally, it replays the packed subtraction word to confirm that the field positions are decoded in the correct order.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

    typedef enum logic [4:0] {
        FS_PASS_A  = 5'b00000,
        FS_INC     = 5'b00001,
        FS_ADD     = 5'b00010,
        FS_ADD_C   = 5'b00011,
        FS_ADD_NB  = 5'b00100,
        FS_SUB     = 5'b00101,
        FS_DEC     = 5'b00110,
        FS_PASS_AC = 5'b00111,
        FS_AND     = 5'b01000,
        FS_OR      = 5'b01010,
        FS_XOR     = 5'b01100,
        FS_NOT     = 5'b01110,
        FS_PASS_B  = 5'b10000,
        FS_SHR     = 5'b10100,
        FS_SHL     = 5'b11000
    } fsel_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic s;
    } flags_t;

endpackage

// File: rtl/cwdp_regbank.sv
module cwdp_regbank #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    localparam int NREG = 1 << AW;

    logic [NREG-1:0][W-1:0] cells;

    assign cells[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < NREG; gi++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cells[gi] <= '0;
                else if (we && (wa == AW'(gi)))
                    cells[gi] <= wd;
            end
        end
    endgenerate

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || wa == '0) |=> $stable(cells)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> cells[$past(wa)] == $past(wd)); // R4

endmodule

// File: rtl/cwdp_funcunit.sv
module cwdp_funcunit
    import cwdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [4:0]   fs,
    output logic [W-1:0] res,
    output flags_t       flg
);
    logic [W-1:0] y_op;
    logic [W-1:0] arith_r;
    logic         arith_c;
    logic         arith_v;
    logic         is_arith;

    always_comb begin
        unique case (fs[2:1])
            2'b00: y_op = '0;
            2'b01: y_op = opb;
            2'b10: y_op = ~opb;
            2'b11: y_op = '1;
        endcase
    end

    assign {arith_c, arith_r} = {1'b0, opa} + {1'b0, y_op} + {{W{1'b0}}, fs[0]};
    assign arith_v  = (opa[W-1] == y_op[W-1]) && (arith_r[W-1] != opa[W-1]);
    assign is_arith = (fs[4:3] == 2'b00);

    always_comb begin
        case (fs)
            FS_PASS_A, FS_INC, FS_ADD, FS_ADD_C,
            FS_ADD_NB, FS_SUB, FS_DEC, FS_PASS_AC: res = arith_r;
            FS_AND:    res = opa & opb;
            FS_OR:     res = opa | opb;
            FS_XOR:    res = opa ^ opb;
            FS_NOT:    res = ~opa;
            FS_PASS_B: res = opb;
            FS_SHR:    res = {1'b0, opb[W-1:1]};
            FS_SHL:    res = {opb[W-2:0], 1'b0};
            default:   res = '0;
        endcase
    end

    always_comb begin
        flg.c = is_arith && arith_c;
        flg.v = is_arith && arith_v;
        flg.z = (res == '0);
        flg.s = res[W-1];
    end

endmodule

// File: rtl/ctlword_datapath.sv
module ctlword_datapath
    import cwdp_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3*AW+7:0]   ctl_word,
    input  logic [W-1:0]      const_in,
    input  logic [W-1:0]      ext_data,
    output logic [W-1:0]      addr_out,
    output logic [W-1:0]      data_out,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_s
);
    localparam int CW_W  = 3 * AW + 8;
    localparam int DA_LO = CW_W - AW;
    localparam int AA_LO = DA_LO - AW;
    localparam int BA_LO = AA_LO - AW;
    localparam int MB_B  = BA_LO - 1;
    localparam int FS_LO = MB_B - 5;
    localparam int MD_B  = 1;
    localparam int RW_B  = 0;

    logic [AW-1:0] da, aa, ba;
    logic          mb, md, rw;
    logic [4:0]    fs;
    logic [W-1:0]  bus_a, reg_b, bus_b, fu_res, wb_data;
    flags_t        fu_flg;

    assign da = ctl_word[DA_LO +: AW];
    assign aa = ctl_word[AA_LO +: AW];
    assign ba = ctl_word[BA_LO +: AW];
    assign mb = ctl_word[MB_B];
    assign fs = ctl_word[FS_LO +: 5];
    assign md = ctl_word[MD_B];
    assign rw = ctl_word[RW_B];

    cwdp_regbank #(.W(W), .AW(AW)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (rw),
        .wa   (da),
        .wd   (wb_data),
        .ra_a (aa),
        .ra_b (ba),
        .rd_a (bus_a),
        .rd_b (reg_b)
    );

    assign bus_b = mb ? const_in : reg_b;

    cwdp_funcunit #(.W(W)) u_fu (
        .opa(bus_a),
        .opb(bus_b),
        .fs (fs),
        .res(fu_res),
        .flg(fu_flg)
    );

    assign wb_data  = md ? ext_data : fu_res;
    assign addr_out = bus_a;
    assign data_out = bus_b;
    assign flag_c   = fu_flg.c;
    assign flag_v   = fu_flg.v;
    assign flag_z   = fu_flg.z;
    assign flag_s   = fu_flg.s;

    AST_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fs[4:3] != 2'b00) |-> (!flag_c && !flag_v)); // R10

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fs == FS_SUB) |-> (flag_c == (addr_out >= data_out))); // R10

    AST_EXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rw && md && da != '0) ##1 (aa == $past(da)) |-> addr_out == $past(ext_data)); // R5

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (aa == '0) |-> (addr_out == '0)); // R6

endmodule

// File: tb/ctlword_datapath_test.sv
module ctlword_datapath_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [16:0]  ctl_word = '0;
    logic [W-1:0] const_in = '0;
    logic [W-1:0] ext_data = '0;
    logic [W-1:0] addr_out, data_out;
    logic         flag_c, flag_v, flag_z, flag_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string        tag;
        logic [W-1:0] ea;
        logic [W-1:0] eb;
        logic [3:0]   ef;
    } item_t;

    item_t sb_q[$];
    logic [W-1:0] mdl [8];

    always #10 clk = ~clk;

    ctlword_datapath uut (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
        .const_in(const_in), .ext_data(ext_data),
        .addr_out(addr_out), .data_out(data_out),
        .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_s(flag_s)
    );

    function automatic void predict(input logic [4:0] f, input logic [W-1:0] a, b,
                                    output logic [W-1:0] r, output logic c, v);
        int ua, ub, sa, sb, u, s;
        ua = int'(a); ub = int'(b);
        sa = int'($signed(a)); sb = int'($signed(b));
        u = 0; s = 0; c = 0; v = 0;
        case (f)
            5'b00000: begin u = ua;            s = sa;          end
            5'b00001: begin u = ua + 1;        s = sa + 1;      end
            5'b00010: begin u = ua + ub;       s = sa + sb;     end
            5'b00011: begin u = ua + ub + 1;   s = sa + sb + 1; end
            5'b00100: begin u = ua + 255 - ub; s = sa - sb - 1; end
            5'b00101: begin u = ua + 256 - ub; s = sa - sb;     end
            5'b00110: begin u = ua + 255;      s = sa - 1;      end
            5'b00111: begin u = ua + 256;      s = sa;          end
            default:  ;
        endcase
        r = u[7:0];
        if (f[4:3] == 2'b00) begin
            c = (u > 255);
            v = (s > 127) || (s < -128);
        end else begin
            case (f)
                5'b01000: r = a & b;
                5'b01010: r = a | b;
                5'b01100: r = a ^ b;
                5'b01110: r = ~a;
                5'b10000: r = b;
                5'b10100: r = b / 2;
                5'b11000: r = W'(ub * 2);
                default:  r = '0;
            endcase
        end
    endfunction

    task automatic drive(input string tag, input logic [16:0] cw,
                         input logic [W-1:0] k, input logic [W-1:0] x);
        item_t it;
        logic [2:0] da, aa, ba;
        logic [4:0] f;
        logic [W-1:0] a, b, r;
        logic c, v;
        @(negedge clk);
        #1;
        ctl_word = cw;
        const_in = k;
        ext_data = x;
        da = cw[16:14]; aa = cw[13:11]; ba = cw[10:8]; f = cw[6:2];
        a = mdl[aa];
        b = cw[7] ? k : mdl[ba];
        predict(f, a, b, r, c, v);
        it.tag = tag;
        it.ea = a;
        it.eb = b;
        it.ef = {c, v, (r == '0), r[W-1]};
        sb_q.push_back(it);
        if (cw[0] && da != 3'd0)
            mdl[da] = cw[1] ? x : r;
    endtask

    task automatic op(input string tag, input logic [2:0] da, aa, ba, input logic mb,
                      input logic [4:0] f, input logic md, rw,
                      input logic [W-1:0] k, input logic [W-1:0] x);
        drive(tag, {da, aa, ba, mb, f, md, rw}, k, x);
    endtask

    initial begin : monitor
        item_t it;
        logic [3:0] got;
        forever begin
            @(negedge clk);
            #8;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                got = {flag_c, flag_v, flag_z, flag_s};
                checks++;
                if (addr_out !== it.ea || data_out !== it.eb || got !== it.ef) begin
                    errors++;
                    $display("FAIL %s: got A=%h B=%h cvzs=%b, expected A=%h B=%h cvzs=%b",
                             it.tag, addr_out, data_out, got, it.ea, it.eb, it.ef);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state on both buses
        op("R1 reset r1/r2", 3'd0, 3'd1, 3'd2, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        op("R1 reset r7/r5", 3'd0, 3'd7, 3'd5, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        // R5 external write-back loads
        op("R5 load r2", 3'd2, 3'd0, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'h50);
        op("R5 load r3", 3'd3, 3'd2, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'h30);
        op("R5 load r4", 3'd4, 3'd3, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'h7F);
        op("R5 load r5", 3'd5, 3'd4, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'h80);
        op("R5 load r6", 3'd6, 3'd5, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'hFF);
        op("R5 load r7", 3'd7, 3'd6, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'h81);
        // R2 field positions: A and B from distinct registers
        op("R2 read r7/r6", 3'd0, 3'd7, 3'd6, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        // R6 write to register 0 ignored
        op("R6 write r0", 3'd0, 3'd0, 3'd0, 0, 5'b00000, 1, 1, 8'h00, 8'hAA);
        op("R6 read r0", 3'd0, 3'd0, 3'd0, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        // R4 write disabled leaves r2
        op("R4 no write", 3'd2, 3'd3, 3'd0, 0, 5'b00000, 1, 0, 8'h00, 8'hEE);
        op("R4 r2 kept", 3'd0, 3'd2, 3'd3, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        // R12 packed subtraction word
        drive("R12 r1=r2-r3", 17'h05315, 8'h00, 8'h00);
        op("R12 r1 read", 3'd0, 3'd1, 3'd0, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        // R7 / R10 arithmetic boundaries
        op("R7 R10 inc 7F", 3'd1, 3'd4, 3'd0, 0, 5'b00001, 0, 1, 8'h00, 8'h00);
        op("R7 R10 inc FF", 3'd1, 3'd6, 3'd1, 0, 5'b00001, 0, 1, 8'h00, 8'h00);
        op("R3 R10 add const", 3'd1, 3'd4, 3'd0, 1, 5'b00010, 0, 1, 8'h01, 8'h00);
        op("R7 add carry", 3'd1, 3'd6, 3'd7, 0, 5'b00010, 0, 1, 8'h00, 8'h00);
        op("R7 add+1", 3'd1, 3'd2, 3'd3, 0, 5'b00011, 0, 1, 8'h00, 8'h00);
        op("R7 a+notb", 3'd1, 3'd2, 3'd3, 0, 5'b00100, 0, 1, 8'h00, 8'h00);
        op("R7 R10 sub self", 3'd1, 3'd2, 3'd2, 0, 5'b00101, 0, 1, 8'h00, 8'h00);
        op("R7 R10 sub borrow", 3'd1, 3'd3, 3'd2, 0, 5'b00101, 0, 1, 8'h00, 8'h00);
        op("R7 R10 dec 80", 3'd1, 3'd5, 3'd1, 0, 5'b00110, 0, 1, 8'h00, 8'h00);
        op("R7 dec zero", 3'd1, 3'd0, 3'd1, 0, 5'b00110, 0, 1, 8'h00, 8'h00);
        op("R7 R10 pass carry", 3'd1, 3'd2, 3'd1, 0, 5'b00111, 0, 1, 8'h00, 8'h00);
        op("R7 pass A", 3'd1, 3'd7, 3'd1, 0, 5'b00000, 0, 1, 8'h00, 8'h00);
        // R8 logic
        op("R8 and", 3'd1, 3'd7, 3'd2, 0, 5'b01000, 0, 1, 8'h00, 8'h00);
        op("R8 or", 3'd1, 3'd2, 3'd3, 0, 5'b01010, 0, 1, 8'h00, 8'h00);
        op("R8 xor", 3'd1, 3'd6, 3'd7, 0, 5'b01100, 0, 1, 8'h00, 8'h00);
        op("R8 not", 3'd1, 3'd6, 3'd0, 0, 5'b01110, 0, 1, 8'h00, 8'h00);
        // R9 shifts with zero fill
        op("R9 shr 81", 3'd1, 3'd1, 3'd7, 0, 5'b10100, 0, 1, 8'h00, 8'h00);
        op("R9 shl 81", 3'd1, 3'd1, 3'd7, 0, 5'b11000, 0, 1, 8'h00, 8'h00);
        op("R3 R9 pass const", 3'd1, 3'd1, 3'd0, 1, 5'b10000, 0, 1, 8'hC3, 8'h00);
        // R11 unlisted codes give zero
        op("R11 code 01001", 3'd1, 3'd1, 3'd6, 0, 5'b01001, 0, 1, 8'h00, 8'h00);
        op("R11 code 11111", 3'd1, 3'd6, 3'd6, 0, 5'b11111, 0, 1, 8'h00, 8'h00);
        op("R11 final read", 3'd0, 3'd1, 3'd7, 0, 5'b00000, 0, 0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule